// File: doc/BRIEF.md
# Parallel NOR Flash Command Front End

This block sits behind the asynchronous, active-low control pins of a parallel NOR flash and turns bus writes into commands for an array engine. It brings the chip-enable, write-enable and output-enable pins, the address bus and the data bus into the system clock domain. It finds each valid write cycle and captures its address and data from the combined chip-enable/write-enable strobe. Each captured write is then passed to a command sequencer.

The sequencer recognises two unlock cycles and then either a program or a sector-erase command. A program emits a one-cycle start pulse carrying the target address and data, and then returns to read. A sector erase emits a start pulse and holds a busy mode until the engine reports completion. While the erase runs it can be suspended and later resumed. Any malformed write drops a partial sequence back to read mode. A reset command abandons a sequence at any point before it completes.

States: `ST_READ`, `ST_UNLK1` (first unlock seen), `ST_UNLK2` (both unlocks seen), `ST_PGM` (waiting for the program target), `ST_ERS1`, `ST_ERS2`, `ST_ERS3` (erase setup and second unlock pair), `ST_EBUSY` (erase running) and `ST_ESUSP` (erase suspended). Transitions:

- read→unlock1 on AAh@555h
- unlock1→unlock2 on 55h@2AAh
- unlock2→program on A0h@555h
- unlock2→erase1 on 80h@555h
- program→read on any write, with a program pulse
- erase1→erase2 on AAh@555h
- erase2→erase3 on 55h@2AAh
- erase3→busy on 30h at any address, with an erase pulse
- busy→suspended on B0h, with a suspend pulse
- suspended→busy on 30h, with a resume pulse
- busy→read on the done input
- every other write in the read, unlock or erase-setup states→read

Top module: `nor_cmd_front`

## Requirements
- R1: After reset, `mode` is 0 (read) and all four pulse outputs are low.
- R2: A write is accepted only while chip-enable and write-enable are both low and output-enable is high. A strobe made while output-enable is low has no effect on `mode`.
- R3: If chip-enable and write-enable are already low, with output-enable high, when reset is released, the end of that strobe is not taken as a write.
- R4: The address is taken when the later of chip-enable and write-enable falls. The data is taken when the earlier of the two rises.
- R5: The sequence AAh@555h, 55h@2AAh, A0h@555h and then a target write gives one `prog_start` pulse. With that pulse, `cap_addr` and `cap_data` hold the target, and `mode` returns to 0. Commands are compared on data bits [7:0] and address bits [10:0].
- R6: The sequence AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh and then 30h at a sector address gives one `erase_start` pulse. With that pulse, `cap_addr` holds the sector address, and `mode` becomes 2 (erase busy).
- R7: In read, unlock or erase-setup states, a write with a wrong address or a wrong data value returns `mode` to 0 without any pulse.
- R8: A write of F0h to any address returns `mode` to 0 from read, from after one unlock cycle, or from after two unlock cycles.
- R9: B0h written in erase busy gives one `susp_pulse`, and `mode` becomes 3. B0h or 30h written in any non-erase state gives no pulse.
- R10: 30h written while suspended gives one `resume_pulse`, and `mode` becomes 2. All other writes in erase busy or suspended change nothing.
- R11: `erase_done` high in erase busy returns `mode` to 0. While suspended, `erase_done` is ignored.
- R12: `mode` encodes 0 = read, 1 = command sequence in progress, 2 = erase busy, 3 = erase suspended. At most one pulse output is high in any cycle, and each pulse lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Address bus |
| din | input | DATA_W | Data bus |
| erase_done | input | 1 | Engine reports the erase has finished |
| mode | output | 2 | Current controller mode |
| prog_start | output | 1 | One-cycle program request |
| erase_start | output | 1 | One-cycle sector-erase request |
| susp_pulse | output | 1 | One-cycle erase-suspend request |
| resume_pulse | output | 1 | One-cycle erase-resume request |
| cap_addr | output | ADDR_W | Captured target or sector address |
| cap_data | output | DATA_W | Captured program data |

## Verification
The assertions assume three things about the inputs:
- Each pin level lasts at least one clock, so that each strobe edge appears exactly once after synchronisation.
- The address and data buses are stable for several clocks around each strobe edge.
- `erase_done` is raised only by an engine that was started.

The stimulus holds every bus value for at least three clocks before a strobe edge and for several clocks after it. It keeps the strobe low for four clocks and pulses `erase_done` for a single cycle, only after an erase has begun.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_CMD   = 2'd1,
        MODE_ERASE = 2'd2,
        MODE_SUSP  = 2'd3
    } mode_e;

    typedef enum logic [3:0] {
        ST_READ,
        ST_UNLK1,
        ST_UNLK2,
        ST_PGM,
        ST_ERS1,
        ST_ERS2,
        ST_ERS3,
        ST_EBUSY,
        ST_ESUSP
    } seq_state_e;

    localparam int unsigned CMD_W      = 8;
    localparam int unsigned KEY_ABITS  = 11;

    localparam logic [CMD_W-1:0] OP_UNLOCK_A = 8'hAA;
    localparam logic [CMD_W-1:0] OP_UNLOCK_B = 8'h55;
    localparam logic [CMD_W-1:0] OP_PROGRAM  = 8'hA0;
    localparam logic [CMD_W-1:0] OP_ERASE    = 8'h80;
    localparam logic [CMD_W-1:0] OP_SECTOR   = 8'h30;
    localparam logic [CMD_W-1:0] OP_SUSPEND  = 8'hB0;
    localparam logic [CMD_W-1:0] OP_RESUME   = 8'h30;
    localparam logic [CMD_W-1:0] OP_RESET    = 8'hF0;

    localparam logic [KEY_ABITS-1:0] KEY_ADDR_A = 11'h555;
    localparam logic [KEY_ABITS-1:0] KEY_ADDR_B = 11'h2AA;

endpackage

// File: rtl/nor_pin_sync.sv
module nor_pin_sync #(
    parameter int unsigned W      = 1,
    parameter int unsigned STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= RST_VAL;
                    else        pipe[s] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) pipe[s] <= RST_VAL;
                    else        pipe[s] <= pipe[s-1];
                end
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/nor_bus_strobe.sv
module nor_bus_strobe #(
    parameter int unsigned ADDR_W      = 22,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              wr_valid,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int unsigned BUS_W = ADDR_W + DATA_W;

    // Reset to the "strobe active" level so that a strobe already held
    // at reset release never shows a leading edge.
    logic [2:0]       ctl_s;
    logic [BUS_W-1:0] bus_s;

    nor_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_ctl_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, oe_n}),
        .q     (ctl_s)
    );

    nor_pin_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, din}),
        .q     (bus_s)
    );

    logic strobe_on;
    logic strobe_q;
    logic in_cycle;

    assign strobe_on = !ctl_s[2] && !ctl_s[1] && ctl_s[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b1;
            in_cycle <= 1'b0;
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            strobe_q <= strobe_on;
            wr_valid <= 1'b0;
            if (strobe_on && !strobe_q) begin
                in_cycle <= 1'b1;
                wr_addr  <= bus_s[BUS_W-1:DATA_W];
            end else if (!strobe_on && strobe_q && in_cycle) begin
                in_cycle <= 1'b0;
                wr_valid <= 1'b1;
                wr_data  <= bus_s[DATA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
    import nor_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 22,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              erase_done,
    output mode_e             mode,
    output logic              prog_start,
    output logic              erase_start,
    output logic              susp_pulse,
    output logic              resume_pulse,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    seq_state_e state, state_nx;
    logic nx_prog, nx_erase, nx_susp, nx_res;
    logic [CMD_W-1:0]     op;
    logic [KEY_ABITS-1:0] key;
    logic at_a, at_b;

    assign op   = wr_data[CMD_W-1:0];
    assign key  = wr_addr[KEY_ABITS-1:0];
    assign at_a = (key == KEY_ADDR_A);
    assign at_b = (key == KEY_ADDR_B);

    always_comb begin
        state_nx = state;
        nx_prog  = 1'b0;
        nx_erase = 1'b0;
        nx_susp  = 1'b0;
        nx_res   = 1'b0;
        unique case (state)
            ST_READ:
                if (wr_valid && op == OP_UNLOCK_A && at_a) state_nx = ST_UNLK1;
            ST_UNLK1:
                if (wr_valid) state_nx = (op == OP_UNLOCK_B && at_b) ? ST_UNLK2 : ST_READ;
            ST_UNLK2:
                if (wr_valid) begin
                    if (op == OP_PROGRAM && at_a)    state_nx = ST_PGM;
                    else if (op == OP_ERASE && at_a) state_nx = ST_ERS1;
                    else                             state_nx = ST_READ;
                end
            ST_PGM:
                if (wr_valid) begin
                    state_nx = ST_READ;
                    nx_prog  = 1'b1;
                end
            ST_ERS1:
                if (wr_valid) state_nx = (op == OP_UNLOCK_A && at_a) ? ST_ERS2 : ST_READ;
            ST_ERS2:
                if (wr_valid) state_nx = (op == OP_UNLOCK_B && at_b) ? ST_ERS3 : ST_READ;
            ST_ERS3:
                if (wr_valid) begin
                    if (op == OP_SECTOR) begin
                        state_nx = ST_EBUSY;
                        nx_erase = 1'b1;
                    end else begin
                        state_nx = ST_READ;
                    end
                end
            ST_EBUSY:
                if (erase_done) state_nx = ST_READ;
                else if (wr_valid && op == OP_SUSPEND) begin
                    state_nx = ST_ESUSP;
                    nx_susp  = 1'b1;
                end
            ST_ESUSP:
                if (wr_valid && op == OP_RESUME) begin
                    state_nx = ST_EBUSY;
                    nx_res   = 1'b1;
                end
            default: state_nx = ST_READ;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READ;
        else        state <= state_nx;
    end

    // Output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prog_start   <= 1'b0;
            erase_start  <= 1'b0;
            susp_pulse   <= 1'b0;
            resume_pulse <= 1'b0;
            cap_addr     <= '0;
            cap_data     <= '0;
        end else begin
            prog_start   <= nx_prog;
            erase_start  <= nx_erase;
            susp_pulse   <= nx_susp;
            resume_pulse <= nx_res;
            if (nx_prog || nx_erase) begin
                cap_addr <= wr_addr;
                cap_data <= wr_data;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_READ:  mode = MODE_READ;
            ST_EBUSY: mode = MODE_ERASE;
            ST_ESUSP: mode = MODE_SUSP;
            default:  mode = MODE_CMD;
        endcase
    end

endmodule

// File: rtl/nor_cmd_front.sv
module nor_cmd_front
    import nor_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W      = 22,
    parameter int unsigned DATA_W      = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              erase_done,
    output logic [1:0]        mode,
    output logic              prog_start,
    output logic              erase_start,
    output logic              susp_pulse,
    output logic              resume_pulse,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [DATA_W-1:0] cap_data
);

    logic              wr_valid;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    mode_e             mode_int;

    nor_bus_strobe #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_strobe (
        .clk      (clk),
        .rst_n    (rst_n),
        .ce_n     (ce_n),
        .we_n     (we_n),
        .oe_n     (oe_n),
        .addr     (addr),
        .din      (din),
        .wr_valid (wr_valid),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data)
    );

    nor_cmd_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid     (wr_valid),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .erase_done   (erase_done),
        .mode         (mode_int),
        .prog_start   (prog_start),
        .erase_start  (erase_start),
        .susp_pulse   (susp_pulse),
        .resume_pulse (resume_pulse),
        .cap_addr     (cap_addr),
        .cap_data     (cap_data)
    );

    assign mode = mode_int;

endmodule

// File: rtl/nor_cmd_front_chk.sv
module nor_cmd_front_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_valid,
    input logic       erase_done,
    input logic [1:0] mode,
    input logic       prog_start,
    input logic       erase_start,
    input logic       susp_pulse,
    input logic       resume_pulse
);

    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({prog_start, erase_start, susp_pulse, resume_pulse}) <= 1); // R12

    AST_PROG_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start); // R12

    AST_PROG_TO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> mode == 2'd0); // R5

    AST_ERASE_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        erase_start |-> mode == 2'd2); // R6

    AST_SUSP_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        susp_pulse |-> ($past(mode) == 2'd2 && mode == 2'd3)); // R9

    AST_RESUME_FROM_SUSP: assert property (@(posedge clk) disable iff (!rst_n)
        resume_pulse |-> ($past(mode) == 2'd3 && mode == 2'd2)); // R10

    AST_DONE_ENDS_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && erase_done) |=> mode == 2'd0); // R11

    AST_MODE_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode != $past(mode)) |-> ($past(wr_valid) || $past(erase_done))); // R2

endmodule

bind nor_cmd_front nor_cmd_front_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_valid     (wr_valid),
    .erase_done   (erase_done),
    .mode         (mode),
    .prog_start   (prog_start),
    .erase_start  (erase_start),
    .susp_pulse   (susp_pulse),
    .resume_pulse (resume_pulse)
);

// File: tb/nor_cmd_front_tb.sv
module nor_cmd_front_tb;

    localparam int ADDR_W = 22;
    localparam int DATA_W = 16;
    localparam int NV     = 30;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic [DATA_W-1:0] din = '0;
    logic erase_done = 1'b0;
    logic [1:0] mode;
    logic prog_start, erase_start, susp_pulse, resume_pulse;
    logic [ADDR_W-1:0] cap_addr;
    logic [DATA_W-1:0] cap_data;

    int checks = 0;
    int fails  = 0;
    int n_prog = 0, n_ers = 0, n_susp = 0, n_res = 0;

    always #5 clk = ~clk;

    nor_cmd_front #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .erase_done(erase_done), .mode(mode),
        .prog_start(prog_start), .erase_start(erase_start),
        .susp_pulse(susp_pulse), .resume_pulse(resume_pulse),
        .cap_addr(cap_addr), .cap_data(cap_data)
    );

    always @(negedge clk) begin
        if (prog_start)   n_prog++;
        if (erase_start)  n_ers++;
        if (susp_pulse)   n_susp++;
        if (resume_pulse) n_res++;
    end

    // {addr[15:0], data[7:0], expected mode[1:0], pulses {prog,erase,susp,res}}
    localparam logic [29:0] VEC [NV] = '{
        {16'h0555, 8'hAA, 2'd1, 4'b0000},  // R8 partial
        {16'h0555, 8'hF0, 2'd0, 4'b0000},  // R8 reset after one unlock
        {16'h0555, 8'hAA, 2'd1, 4'b0000},
        {16'h0123, 8'h55, 2'd0, 4'b0000},  // R7 wrong address
        {16'h0555, 8'hAA, 2'd1, 4'b0000},
        {16'h02AA, 8'h55, 2'd1, 4'b0000},
        {16'h0555, 8'h90, 2'd0, 4'b0000},  // R7 wrong data
        {16'h0000, 8'hB0, 2'd0, 4'b0000},  // R9 suspend outside erase
        {16'h0000, 8'h30, 2'd0, 4'b0000},  // R9 resume outside erase
        {16'h0777, 8'hF0, 2'd0, 4'b0000},  // R8 reset in read
        {16'h0555, 8'hAA, 2'd1, 4'b0000},
        {16'h02AA, 8'h55, 2'd1, 4'b0000},
        {16'h0007, 8'hF0, 2'd0, 4'b0000},  // R8 reset after two unlocks
        {16'h0555, 8'hAA, 2'd1, 4'b0000},
        {16'h02AA, 8'h55, 2'd1, 4'b0000},
        {16'h0555, 8'hA0, 2'd1, 4'b0000},
        {16'h1234, 8'h5C, 2'd0, 4'b1000},  // R5 program
        {16'h0555, 8'hAA, 2'd1, 4'b0000},
        {16'h02AA, 8'h55, 2'd1, 4'b0000},
        {16'h0555, 8'h80, 2'd1, 4'b0000},
        {16'h0555, 8'hAA, 2'd1, 4'b0000},
        {16'h02AA, 8'h55, 2'd1, 4'b0000},
        {16'h4000, 8'h30, 2'd2, 4'b0100},  // R6 sector erase
        {16'h0055, 8'h55, 2'd2, 4'b0000},  // R10 ignored in busy
        {16'h0000, 8'h30, 2'd2, 4'b0000},  // R10 resume ignored in busy
        {16'h0000, 8'hB0, 2'd3, 4'b0010},  // R9 suspend
        {16'h0000, 8'hB0, 2'd3, 4'b0000},  // R10 ignored in suspend
        {16'h0000, 8'hF0, 2'd3, 4'b0000},  // R10 reset ignored in suspend
        {16'h0000, 8'h30, 2'd2, 4'b0001},  // R10 resume
        {16'h0000, 8'hB0, 2'd3, 4'b0010}   // R9 suspend again
    };

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                          input logic oe_lvl);
        @(negedge clk);
        addr = a; din = d; oe_n = oe_lvl;
        repeat (3) @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0;
        repeat (4) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (7) @(negedge clk);
        oe_n = 1'b1;
    endtask

    task automatic pulse_done();
        @(negedge clk); erase_done = 1'b1;
        @(negedge clk); erase_done = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        do_reset();
        // R1 reset state
        check(mode == 2'd0, "R1 mode", mode, 0);
        check({prog_start, erase_start, susp_pulse, resume_pulse} == 4'b0, "R1 pulses",
              {prog_start, erase_start, susp_pulse, resume_pulse}, 0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            int p0, e0, s0, r0;
            logic [3:0] got;
            p0 = n_prog; e0 = n_ers; s0 = n_susp; r0 = n_res;
            bus_wr({6'd0, VEC[i][29:14]}, {8'd0, VEC[i][13:6]}, 1'b1);
            check(mode == VEC[i][5:4], $sformatf("R12 vec %0d mode", i), mode, VEC[i][5:4]);
            got = {n_prog != p0, n_ers != e0, n_susp != s0, n_res != r0};
            check(got == VEC[i][3:0] && (n_prog - p0) <= 1 && (n_ers - e0) <= 1,
                  $sformatf("R12 vec %0d pulses", i), got, VEC[i][3:0]);
            if (VEC[i][3] || VEC[i][2])
                check(cap_addr == {6'd0, VEC[i][29:14]}, $sformatf("R6 vec %0d cap_addr", i),
                      cap_addr, VEC[i][29:14]);
            if (VEC[i][3])
                check(cap_data == {8'd0, VEC[i][13:6]}, "R5 cap_data", cap_data, VEC[i][13:6]);
        end

        // R11 done ignored while suspended, honoured while busy
        pulse_done();
        check(mode == 2'd3, "R11 done in suspend", mode, 3);
        bus_wr(22'h0, 16'h0030, 1'b1);
        check(mode == 2'd2, "R10 resume", mode, 2);
        pulse_done();
        check(mode == 2'd0, "R11 done in busy", mode, 0);

        // R2 output-enable low blocks the write
        bus_wr(22'h555, 16'h00AA, 1'b0);
        check(mode == 2'd0, "R2 oe inhibit", mode, 0);
        bus_wr(22'h555, 16'h00AA, 1'b1);
        check(mode == 2'd1, "R2 normal write", mode, 1);
        bus_wr(22'h0, 16'h00F0, 1'b1);

        // R3 strobe already active at reset release
        @(negedge clk);
        rst_n = 1'b0; addr = 22'h555; din = 16'h00AA; oe_n = 1'b1;
        ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
        repeat (7) @(negedge clk);
        check(mode == 2'd0, "R3 power-up strobe", mode, 0);
        bus_wr(22'h555, 16'h00AA, 1'b1);
        check(mode == 2'd1, "R3 next write taken", mode, 1);

        // R4 later falling edge for address, earlier rising edge for data
        bus_wr(22'h2AA, 16'h0055, 1'b1);
        bus_wr(22'h555, 16'h00A0, 1'b1);
        begin
            int p0;
            p0 = n_prog;
            @(negedge clk);
            addr = 22'h00AAAA; din = 16'h1111;
            repeat (3) @(negedge clk);
            we_n = 1'b0;
            repeat (4) @(negedge clk);
            addr = 22'h033333;
            repeat (4) @(negedge clk);
            ce_n = 1'b0;
            repeat (4) @(negedge clk);
            ce_n = 1'b1;
            repeat (4) @(negedge clk);
            din = 16'h2222;
            repeat (4) @(negedge clk);
            we_n = 1'b1;
            repeat (7) @(negedge clk);
            check(n_prog - p0 == 1, "R4 one program", n_prog - p0, 1);
            check(cap_addr == 22'h033333, "R4 address at later fall", cap_addr, 22'h033333);
            check(cap_data == 16'h1111, "R4 data at earlier rise", cap_data, 16'h1111);
            check(mode == 2'd0, "R5 back to read", mode, 0);
        end

        report();
    end

endmodule